// File: doc/BRIEF.md
# Mixed-Granularity GPIO Port Controller

This block holds the port registers of a small 4-bit microcontroller: nine I/O ports, numbered 0 to 8, each with an output latch, a direction register and a pull-up register. Ports 0 and 1 are input-only. Port 8 is two bits wide. Ports 4 and 5 can only pull their pins low (open-drain). The other ports drive their pins both high and low (push-pull). The ports differ in how finely software sets direction and pull-ups: on some ports each bit is set on its own, on others a whole group of bits is set together.

Software uses a synchronous register interface. Each access picks a port number, a register kind (data, direction or pull-up) and a width. A 4-bit access reaches one port. An 8-bit access reaches the port pairs 4/5 and 6/7. At the pin side the block drives an output value, an output enable and a pull-up enable for every pin. It also registers the pin input values once per clock, and reads of input-mode bits return these registered values. Analog pad behaviour, alternate pin functions and factory-fixed pull-ups are outside the block; the factory-fixed pull-ups enter only as a parameter.

Top module: `gpio_mg_top`

## Requirements
- R1: After reset, every latch, direction bit and software pull-up bit is 0, and no pin has its output enable set.
- R2: On ports 0 and 1, writes to the data and direction registers have no effect. Their output enables stay 0, and a data read returns the registered pin values.
- R3: On ports 3 and 6, a direction write copies wr_data[3:0] bit for bit (1 = output, 0 = input).
- R4: On ports 2, 4, 5 and 7, a direction write sets all four bits to wr_data[0]. On port 8 it sets both bits to wr_data[0].
- R5: A data read returns, for each bit, the latch value when the bit is an output and the registered pin value when it is an input. Pin values are registered once per clock. Bits 3:2 of port 8 always read 0.
- R6: On push-pull ports (2, 3, 6, 7, 8), pin_out follows the latch and pin_oe follows the direction bit.
- R7: On open-drain ports (4, 5), pin_out is always 0. pin_oe is set only when the bit is an output and its latch is 0; a latch value of 1 releases the pin.
- R8: An 8-bit data access with addr 4 or 6 reaches the pair (addr, addr+1). The low byte-nibble belongs to the even port and the high nibble to the odd port, and a wide write updates both ports at the same clock edge. A wide access to any other address, or to a register kind other than data, writes nothing and reads 0.
- R9: A pull-up write (sel 2) sets a group from wr_data[0]: bits 3:1 on port 0 (bit 0 stays 0), all four bits on ports 1, 2, 3, 6 and 7, and bits 1:0 on port 8. Ports 4 and 5 take their pull-ups from the OD_PULLUP parameter (port 4 in bits 3:0, port 5 in bits 7:4), cannot be written, and read back that value.
- R10: pin_pu is forced to 0 on any pin whose pin_oe is 1.
- R11: Register kind encoding: sel 0 = data, 1 = direction, 2 = pull-up, 3 = reserved. Writes to sel 3 or to addr above 8 have no effect, and such reads return 0. Direction and pull-up reads return the stored per-bit value in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, takes effect at the clock edge |
| wide | input | 1 | 1 = 8-bit paired access, 0 = 4-bit access |
| sel | input | 2 | Register kind: 0 data, 1 direction, 2 pull-up, 3 reserved |
| addr | input | 4 | Port number |
| wr_data | input | 8 | Write value |
| rd_data | output | 8 | Combinational read value for sel/addr/wide |
| pin_in | input | 36 | Pin inputs, port p in bits [4p+3:4p] |
| pin_out | output | 36 | Pin output values |
| pin_oe | output | 36 | Pin output enables |
| pin_pu | output | 36 | Pin pull-up enables |

## Verification
A wrong direction or latch bit appears on pin_oe or pin_out right after the clock edge of the write that caused it. It also appears in the next data read, because that bit then returns the pin value instead of the latch value, or the reverse. A group-granularity mistake shows up as an output enable on a neighbouring bit that should have stayed an input. A wrong open-drain release or pull-up gating appears combinationally on pin_oe and pin_pu in the same cycle that the latch or direction changes. The bench repeats every port's full register and pin check after each write and each change of pin pattern, so a fault is reported at the first step that exposes it.

// File: rtl/gpio_mg_pkg.sv
package gpio_mg_pkg;

  localparam int NPORT  = 9;
  localparam int NIB    = 4;
  localparam int PIN_W  = NPORT * NIB;
  localparam int ADDR_W = 4;
  localparam int NSLOT  = 1 << ADDR_W;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PU   = 2'd2,
    SEL_RSVD = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    DG_NONE  = 2'd0,
    DG_BIT   = 2'd1,
    DG_GROUP = 2'd2
  } dgran_e;

  function automatic logic [NIB-1:0] port_mask(int p);
    return (p == 8) ? 4'b0011 : 4'b1111;
  endfunction

  function automatic logic is_input_only(int p);
    return (p == 0) || (p == 1);
  endfunction

  function automatic logic is_open_drain(int p);
    return (p == 4) || (p == 5);
  endfunction

  function automatic dgran_e dir_gran(int p);
    if (is_input_only(p)) return DG_NONE;
    if (p == 3 || p == 6) return DG_BIT;
    return DG_GROUP;
  endfunction

  // bits a software pull-up write reaches
  function automatic logic [NIB-1:0] pu_group(int p);
    if (p == 0) return 4'b1110;
    if (is_open_drain(p)) return 4'b0000;
    return port_mask(p);
  endfunction

  function automatic logic [NIB-1:0] expand_dir(int p, logic [NIB-1:0] d);
    case (dir_gran(p))
      DG_BIT:   return d & port_mask(p);
      DG_GROUP: return d[0] ? port_mask(p) : 4'b0000;
      default:  return 4'b0000;
    endcase
  endfunction

  function automatic logic [NIB-1:0] expand_pu(int p, logic [NIB-1:0] d);
    return d[0] ? pu_group(p) : 4'b0000;
  endfunction

  function automatic logic pair_base(logic [ADDR_W-1:0] a);
    return (a == 4'd4) || (a == 4'd6);
  endfunction

endpackage

// File: rtl/gpio_mg_sampler.sv
module gpio_mg_sampler #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] smp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp <= '0;
    else        smp <= raw;
  end
endmodule

// File: rtl/gpio_mg_slice.sv
module gpio_mg_slice
  import gpio_mg_pkg::*;
#(
  parameter int             PIDX    = 2,
  parameter logic [NIB-1:0] FIXED_PU = 4'b0000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we_data,
  input  logic           we_dir,
  input  logic           we_pu,
  input  logic [NIB-1:0] wr_nib,
  input  logic [NIB-1:0] pin_smp,
  output logic [NIB-1:0] rd_data,
  output logic [NIB-1:0] rd_dir,
  output logic [NIB-1:0] rd_pu,
  output logic [NIB-1:0] pin_out,
  output logic [NIB-1:0] pin_oe,
  output logic [NIB-1:0] pin_pu
);
  localparam logic [NIB-1:0] MASK   = port_mask(PIDX);
  localparam logic           IN_ONLY = is_input_only(PIDX);
  localparam logic           OD      = is_open_drain(PIDX);

  logic [NIB-1:0] lat_q, dir_q, pu_q, pu_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '0;
      pu_q  <= '0;
    end else begin
      if (we_data && !IN_ONLY) lat_q <= wr_nib & MASK;
      if (we_dir)              dir_q <= expand_dir(PIDX, wr_nib);
      if (we_pu)               pu_q  <= expand_pu(PIDX, wr_nib);
    end
  end

  generate
    if (OD) begin : g_od
      assign pin_out = '0;
      assign pin_oe  = dir_q & ~lat_q & MASK;
      assign pu_src  = FIXED_PU & MASK;
    end else begin : g_pp
      assign pin_out = lat_q;
      assign pin_oe  = dir_q;
      assign pu_src  = pu_q;
    end
  endgenerate

  assign pin_pu  = pu_src & ~pin_oe;
  assign rd_data = ((dir_q & lat_q) | (~dir_q & pin_smp)) & MASK;
  assign rd_dir  = dir_q;
  assign rd_pu   = pu_src;

  generate
    if (OD) begin : g_chk_od
      assert_od_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        we_data |=> ((pin_oe & $past(wr_nib)) == 4'b0000));
    end
    if (IN_ONLY) begin : g_chk_in
      assert_inonly_reads_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data == pin_smp) && (pin_oe == 4'b0000));
    end else begin : g_chk_out
      assert_rd_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we_data |=> (((rd_data ^ $past(wr_nib)) & dir_q & MASK) == 4'b0000));
    end
    if (dir_gran(PIDX) == DG_GROUP) begin : g_chk_grp
      assert_dir_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q == 4'b0000) || (dir_q == MASK));
    end
  endgenerate
endmodule

// File: rtl/gpio_mg_top.sv
module gpio_mg_top
  import gpio_mg_pkg::*;
#(
  parameter logic [7:0] OD_PULLUP = 8'b1010_0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wide,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe,
  output logic [PIN_W-1:0]  pin_pu
);
  logic [PIN_W-1:0] pin_smp;
  logic [NPORT-1:0] we_data, we_dir, we_pu;
  logic [NIB-1:0]   rd_d [NSLOT];
  logic [NIB-1:0]   rd_r [NSLOT];
  logic [NIB-1:0]   rd_p [NSLOT];
  logic             pair_ok;
  logic [ADDR_W-1:0] addr_hi;

  assign pair_ok = pair_base(addr);
  assign addr_hi = addr + 4'd1;

  gpio_mg_sampler #(.W(PIN_W)) sampler_i (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .smp(pin_smp)
  );

  for (genvar p = 0; p < NSLOT; p++) begin : g_port
    if (p < NPORT) begin : g_live
      logic [NIB-1:0] nib;
      assign nib = (wide && (p % 2 == 1)) ? wr_data[7:4] : wr_data[3:0];
      assign we_data[p] = wr_en && (sel == SEL_DATA) &&
        (wide ? (pair_ok && (addr == 4'(p) || addr_hi == 4'(p))) : (addr == 4'(p)));
      assign we_dir[p] = wr_en && !wide && (sel == SEL_DIR) && (addr == 4'(p));
      assign we_pu[p]  = wr_en && !wide && (sel == SEL_PU)  && (addr == 4'(p));

      gpio_mg_slice #(
        .PIDX(p),
        .FIXED_PU((p == 4) ? OD_PULLUP[3:0] : (p == 5) ? OD_PULLUP[7:4] : 4'b0000)
      ) slice_i (
        .clk(clk), .rst_n(rst_n),
        .we_data(we_data[p]), .we_dir(we_dir[p]), .we_pu(we_pu[p]),
        .wr_nib(nib), .pin_smp(pin_smp[4*p +: 4]),
        .rd_data(rd_d[p]), .rd_dir(rd_r[p]), .rd_pu(rd_p[p]),
        .pin_out(pin_out[4*p +: 4]), .pin_oe(pin_oe[4*p +: 4]), .pin_pu(pin_pu[4*p +: 4])
      );
    end else begin : g_void
      assign rd_d[p] = '0;
      assign rd_r[p] = '0;
      assign rd_p[p] = '0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (wide) begin
      if (sel == SEL_DATA && pair_ok) rd_data = {rd_d[addr_hi], rd_d[addr]};
    end else begin
      case (sel)
        SEL_DATA: rd_data = {4'b0000, rd_d[addr]};
        SEL_DIR:  rd_data = {4'b0000, rd_r[addr]};
        SEL_PU:   rd_data = {4'b0000, rd_p[addr]};
        default:  rd_data = '0;
      endcase
    end
  end

  assert_pu_off_when_driving_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & pin_pu) == '0);

  assert_wide_pair_same_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wide && sel == SEL_DATA && addr == 4'd6) |-> (we_data[6] && we_data[7] && !we_data[4]));

  assert_reset_no_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0));
endmodule

// File: tb/gpio_mg_top_tb_top.sv
module gpio_mg_top_tb_top;
  localparam logic [7:0] ODPU = 8'b1010_0101;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wide = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [3:0]  addr = 4'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [7:0]  rd_data;
  logic [35:0] pin_in = 36'd0, pin_out, pin_oe, pin_pu;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [3:0] mlat [9];
  logic [3:0] mdir [9];
  logic [3:0] mpu  [9];

  always #5 clk = ~clk;

  gpio_mg_top #(.OD_PULLUP(ODPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wide(wide), .sel(sel), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  function automatic logic [3:0] bmask(int p);
    return (p == 8) ? 4'h3 : 4'hF;
  endfunction
  function automatic bit od(int p);
    return p == 4 || p == 5;
  endfunction
  function automatic logic [3:0] nx_dir(int p, logic [3:0] d);
    if (p < 2) return 4'h0;
    if (p == 3 || p == 6) return d;
    return {4{d[0]}} & bmask(p);
  endfunction
  function automatic logic [3:0] nx_pu(int p, logic [3:0] d, logic [3:0] old);
    if (od(p)) return old;
    if (p == 0) return {{3{d[0]}}, 1'b0};
    return {4{d[0]}} & bmask(p);
  endfunction
  function automatic logic [3:0] nx_lat(int p, logic [3:0] d, logic [3:0] old);
    if (p < 2) return old;
    return d & bmask(p);
  endfunction
  function automatic logic [3:0] pu_rd(int p);
    if (p == 4) return ODPU[3:0];
    if (p == 5) return ODPU[7:4];
    return mpu[p];
  endfunction
  function automatic logic [3:0] e_oe(int p);
    return od(p) ? (mdir[p] & ~mlat[p]) : mdir[p];
  endfunction
  function automatic logic [3:0] e_rd(int p);
    return ((mdir[p] & mlat[p]) | (~mdir[p] & pin_in[4*p +: 4])) & bmask(p);
  endfunction

  task automatic chk(logic [7:0] got, logic [7:0] exp, string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [3:0] a, bit w, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; sel = s; addr = a; wide = w; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wide = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, logic [3:0] a, bit w, output logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b0; sel = s; addr = a; wide = w;
    #1 v = rd_data;
    wide = 1'b0;
  endtask

  // model-side register write, mirrors the requirement text
  task automatic mwr(logic [1:0] s, int p, logic [3:0] d);
    if (s == 2'd0) mlat[p] = nx_lat(p, d, mlat[p]);
    if (s == 2'd1) mdir[p] = nx_dir(p, d);
    if (s == 2'd2) mpu[p]  = nx_pu(p, d, mpu[p]);
  endtask

  task automatic check_all(string ctx);
    logic [7:0] v;
    for (int p = 0; p < 9; p++) begin
      rd(2'd0, 4'(p), 1'b0, v);
      chk(v, {4'h0, e_rd(p)}, $sformatf("%s %s data port %0d", ctx, (p < 2) ? "R2" : "R5", p));
      rd(2'd1, 4'(p), 1'b0, v);
      chk(v, {4'h0, mdir[p]}, $sformatf("%s %s dir port %0d", ctx,
          (p == 3 || p == 6) ? "R3" : "R4", p));
      rd(2'd2, 4'(p), 1'b0, v);
      chk(v, {4'h0, pu_rd(p)}, $sformatf("%s R9 pu read port %0d", ctx, p));
      chk({4'h0, pin_out[4*p +: 4]}, {4'h0, od(p) ? 4'h0 : mlat[p]},
          $sformatf("%s %s pin_out port %0d", ctx, od(p) ? "R7" : "R6", p));
      chk({4'h0, pin_oe[4*p +: 4]}, {4'h0, e_oe(p)},
          $sformatf("%s %s pin_oe port %0d", ctx, od(p) ? "R7" : "R6", p));
      chk({4'h0, pin_pu[4*p +: 4]}, {4'h0, pu_rd(p) & ~e_oe(p)},
          $sformatf("%s R10 pin_pu port %0d", ctx, p));
    end
  endtask

  task automatic set_pins(logic [35:0] v);
    @(negedge clk);
    pin_in = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v;
    logic [35:0] lf;
    logic [3:0]  vals [6] = '{4'h5, 4'hA, 4'hF, 4'h0, 4'h3, 4'hC};
    for (int p = 0; p < 9; p++) begin mlat[p] = 0; mdir[p] = 0; mpu[p] = 0; end
    pin_in = 36'h9_A5C3_7E1B;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({4'h0, (pin_oe == 36'd0) ? 4'h1 : 4'h0}, 8'h01, "R1 no output enable after reset");
    check_all("R1");

    // every port, every register kind, several value patterns
    lf = 36'h5_3C96_A0F1;
    for (int p = 0; p < 9; p++) begin
      for (int k = 0; k < 6; k++) begin
        wr(2'd1, 4'(p), 1'b0, {4'h0, vals[k]});      mwr(2'd1, p, vals[k]);
        wr(2'd0, 4'(p), 1'b0, {4'h0, vals[k] ^ 4'h6}); mwr(2'd0, p, vals[k] ^ 4'h6);
        wr(2'd2, 4'(p), 1'b0, {4'h0, vals[5-k]});    mwr(2'd2, p, vals[5-k]);
        lf = {lf[34:0], lf[35] ^ lf[24]};
        set_pins(lf);
        check_all("sweep");
      end
    end

    // pin pattern sweep with current mixed state
    for (int k = 0; k < 12; k++) begin
      lf = {lf[33:0], lf[35] ^ lf[24], lf[34] ^ lf[23]};
      set_pins(lf ^ {9{4'(k)}});
      check_all("R5 pins");
    end

    // paired 8-bit access
    for (int p = 4; p < 8; p++) begin wr(2'd1, 4'(p), 1'b0, 8'h0F); mwr(2'd1, p, 4'hF); end
    wr(2'd0, 4'd6, 1'b1, 8'h3C); mwr(2'd0, 6, 4'hC); mwr(2'd0, 7, 4'h3);
    rd(2'd0, 4'd6, 1'b1, v); chk(v, 8'h3C, "R8 wide read 6/7");
    wr(2'd0, 4'd4, 1'b1, 8'h96); mwr(2'd0, 4, 4'h6); mwr(2'd0, 5, 4'h9);
    rd(2'd0, 4'd4, 1'b1, v); chk(v, 8'h96, "R8 wide read 4/5");
    chk(pin_oe[23:16], 8'h69, "R8 R7 wide write reaches both open-drain ports");
    check_all("R8 after wide");
    wr(2'd0, 4'd5, 1'b1, 8'hFF);
    rd(2'd0, 4'd5, 1'b1, v); chk(v, 8'h00, "R8 wide odd address reads 0");
    wr(2'd1, 4'd6, 1'b1, 8'h00);
    rd(2'd1, 4'd6, 1'b1, v); chk(v, 8'h00, "R8 wide dir reads 0");
    check_all("R8 ignored wide");

    // reserved kind and out-of-range port
    wr(2'd3, 4'd2, 1'b0, 8'hFF);
    rd(2'd3, 4'd2, 1'b0, v); chk(v, 8'h00, "R11 reserved sel reads 0");
    for (int a = 9; a < 16; a++) begin
      wr(2'd0, 4'(a), 1'b0, 8'hFF);
      wr(2'd1, 4'(a), 1'b0, 8'hFF);
      rd(2'd0, 4'(a), 1'b0, v); chk(v, 8'h00, $sformatf("R11 addr %0d reads 0", a));
    end
    check_all("R11 ignored");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule